// File: doc/BRIEF.md
# ISA I/O and Expansion-ROM Address Decoder

This block sits on the host side of an ISA-style peripheral and decides, from the current bus address, whether a cycle targets the card. A single 16-bit base register drives two decoders. Its upper byte places a 16-location window anywhere in the 64K I/O space. The compare is sparse: eight address lines are programmable, and four further lines must be zero. Its lower byte holds a size code and a base for an optional read-only expansion ROM window in memory space. The ROM compare covers fewer lines as the window grows.

The base register is written by the host, or loaded by a pulse from a serial configuration store, and the load wins when both arrive together. This happens only in ISA mode. In PCMCIA mode the register presents its power-on value, refuses every update and keeps that value once ISA mode returns. The hit and select outputs are combinational from the registered base and the live bus inputs. Register updates pass through a four-way update selector: HOLD keeps the value, HOST takes the host word, LOAD takes the configuration word, and FORCE restores the power-on value. The choice goes to FORCE when PCMCIA mode is selected, otherwise to LOAD when a load pulse is present, otherwise to HOST when a host write is present, and otherwise to HOLD.

Top module: `isa_addr_decode`

## Requirements
- R1: After reset the base register reads back 0x1867. This gives an I/O base of 0x300, ROM size code 01 and a ROM base of 0xCC000.
- R2: `io_hit` is 1 exactly when io_addr[15:13] equals base[15:13], io_addr[9:5] equals base[12:8], and io_addr[12:10] and io_addr[4] are all zero.
- R3: `io_offset` equals io_addr[3:0] while `io_hit` is 1, and is 0 otherwise.
- R4: The ROM size code is base[7:6] and the ROM compare value is base[5:1], where base[5] is matched against mem_addr[18]. Code 01 compares mem_addr[18:14] with base[5:1]. Code 10 compares mem_addr[18:15] with base[5:2]. Code 11 compares mem_addr[18:16] with base[5:3].
- R5: `rom_sel` also requires mem_addr[19]=1 and `mem_rd_n`=0. mem_addr[23:20] and mem_addr[13:0] have no effect on it.
- R6: With ROM size code 00, `rom_sel` stays 0 for every address.
- R7: In ISA mode, a host write (`host_wr_en`=1) stores `host_wr_data` at the next clock edge, and it is visible on `base_rdata` after that edge.
- R8: In ISA mode, a load pulse (`load_en`=1) stores `load_data` at the next edge, even when a host write arrives in the same cycle.
- R9: While `mode_pcmcia`=1, `base_rdata` is 0x1867 and the decoders use that value. Host writes and loads have no effect. After a return to ISA mode the register still reads 0x1867.
- R10: base[0] is reserved. It always reads back 1, whatever value is written or loaded, and it takes part in no compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_pcmcia | input | 1 | 1 = PCMCIA mode, 0 = ISA mode |
| io_addr | input | 16 | I/O bus address |
| mem_addr | input | 24 | Memory bus address |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| host_wr_en | input | 1 | Host write of the base register |
| host_wr_data | input | 16 | Host write data |
| load_en | input | 1 | Load pulse from the configuration store |
| load_data | input | 16 | Configuration store word |
| io_hit | output | 1 | I/O window hit |
| io_offset | output | 4 | Register offset within the window |
| rom_sel | output | 1 | Expansion ROM select |
| base_rdata | output | 16 | Base register readback |

## Verification
The I/O decode is swept over all 65536 addresses for three bases: the default, all ones and an alternating pattern. This separates each programmable line from the must-be-zero lines and catches a mis-wired bit position. The ROM decode is swept over mem_addr[23:14] and both strobe levels for each of the four size codes. This shows which compare lines each code drops, that A19 is required and that A23-A20 are ignored. Update-path tests put a write and a load in the same cycle, and send writes and loads in PCMCIA mode. These separate the load-over-write priority from the PCMCIA lockout and from the forced reserved bit.

// File: rtl/isadec_pkg.sv
package isadec_pkg;
    localparam int          BASE_W       = 16;
    localparam logic [15:0] BASE_DEFAULT = 16'h1867;
    localparam int          IO_ADDR_W    = 16;
    localparam int          MEM_ADDR_W   = 24;
    localparam int          ROM_CMP_W    = 5;
    localparam int          ROM_CMP_LSB  = 14;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_HOST,
        UPD_LOAD,
        UPD_FORCE
    } upd_e;

    typedef enum logic [1:0] {
        ROM_OFF = 2'b00,
        ROM_16K = 2'b01,
        ROM_32K = 2'b10,
        ROM_64K = 2'b11
    } rom_size_e;
endpackage

// File: rtl/isadec_basereg.sv
module isadec_basereg
    import isadec_pkg::*;
#(
    parameter int          W       = BASE_W,
    parameter logic [15:0] DEFAULT = BASE_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_pcmcia,
    input  logic         host_wr_en,
    input  logic [W-1:0] host_wr_data,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] base_q
);
    localparam logic [W-1:0] RESET_VAL = W'(DEFAULT);

    upd_e         upd_sel;
    logic [W-1:0] stored_q;
    logic [W-1:0] next_val;

    // Update source selection: mode lockout first, then load, then host.
    always_comb begin
        if (mode_pcmcia)     upd_sel = UPD_FORCE;
        else if (load_en)    upd_sel = UPD_LOAD;
        else if (host_wr_en) upd_sel = UPD_HOST;
        else                 upd_sel = UPD_HOLD;
    end

    always_comb begin
        unique case (upd_sel)
            UPD_HOLD:  next_val = stored_q;
            UPD_HOST:  next_val = host_wr_data;
            UPD_LOAD:  next_val = load_data;
            UPD_FORCE: next_val = RESET_VAL;
            default:   next_val = stored_q;
        endcase
        next_val[0] = 1'b1;   // reserved bit
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stored_q <= RESET_VAL;
        else        stored_q <= next_val;
    end

    assign base_q = mode_pcmcia ? RESET_VAL : stored_q;
endmodule

// File: rtl/isadec_io_match.sv
module isadec_io_match
    import isadec_pkg::*;
#(
    parameter int AW = IO_ADDR_W
) (
    input  logic [7:0]    cfg,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [3:0]    offset
);
    // cfg bits 4:0 -> A9..A5, cfg bits 7:5 -> A15..A13
    function automatic int bit_pos(input int i);
        return (i < 5) ? (5 + i) : (13 + (i - 5));
    endfunction

    logic [7:0] eq;

    for (genvar i = 0; i < 8; i++) begin : g_cmp
        assign eq[i] = (cfg[i] == addr[bit_pos(i)]);
    end

    logic zero_ok;
    assign zero_ok = (addr[12:10] == 3'b000) && !addr[4];
    assign hit     = (&eq) && zero_ok;
    assign offset  = hit ? addr[3:0] : 4'h0;
endmodule

// File: rtl/isadec_rom_match.sv
module isadec_rom_match
    import isadec_pkg::*;
#(
    parameter int AW    = MEM_ADDR_W,
    parameter int CMP_W = ROM_CMP_W,
    parameter int LSB   = ROM_CMP_LSB
) (
    input  logic [7:0]    cfg,
    input  logic [AW-1:0] addr,
    input  logic          rd_n,
    output logic          sel
);
    localparam int ENA_BIT = LSB + CMP_W;

    rom_size_e        size_code;
    logic [CMP_W-1:0] ra;
    logic [CMP_W-1:0] used;
    logic [CMP_W-1:0] ok;

    assign size_code = rom_size_e'(cfg[7:6]);
    assign ra        = cfg[CMP_W:1];

    // Larger windows drop the low compare lines.
    for (genvar i = 0; i < CMP_W; i++) begin : g_cmp
        assign used[i] = ({30'd0, cfg[7:6]} <= 32'(i + 1));
        assign ok[i]   = !used[i] || (ra[i] == addr[LSB + i]);
    end

    assign sel = (size_code != ROM_OFF) && (&ok) && addr[ENA_BIT] && !rd_n;
endmodule

// File: rtl/isa_addr_decode.sv
module isa_addr_decode
    import isadec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_pcmcia,
    input  logic [15:0] io_addr,
    input  logic [23:0] mem_addr,
    input  logic        mem_rd_n,
    input  logic        host_wr_en,
    input  logic [15:0] host_wr_data,
    input  logic        load_en,
    input  logic [15:0] load_data,
    output logic        io_hit,
    output logic [3:0]  io_offset,
    output logic        rom_sel,
    output logic [15:0] base_rdata
);
    logic [BASE_W-1:0] base_q;

    isadec_basereg #(.W(BASE_W), .DEFAULT(BASE_DEFAULT)) u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_pcmcia  (mode_pcmcia),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .load_en      (load_en),
        .load_data    (load_data),
        .base_q       (base_q)
    );

    isadec_io_match #(.AW(IO_ADDR_W)) u_io (
        .cfg    (base_q[15:8]),
        .addr   (io_addr),
        .hit    (io_hit),
        .offset (io_offset)
    );

    isadec_rom_match #(.AW(MEM_ADDR_W), .CMP_W(ROM_CMP_W), .LSB(ROM_CMP_LSB)) u_rom (
        .cfg  (base_q[7:0]),
        .addr (mem_addr),
        .rd_n (mem_rd_n),
        .sel  (rom_sel)
    );

    assign base_rdata = base_q;
endmodule

// File: rtl/isadec_checker.sv
module isadec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_pcmcia,
    input logic [15:0] io_addr,
    input logic [23:0] mem_addr,
    input logic        mem_rd_n,
    input logic        host_wr_en,
    input logic [15:0] host_wr_data,
    input logic        load_en,
    input logic [15:0] load_data,
    input logic        io_hit,
    input logic [3:0]  io_offset,
    input logic        rom_sel,
    input logic [15:0] base_rdata
);
    assert_io_zero_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> (io_addr[12:10] == 3'b000 && !io_addr[4]));

    assert_offset_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hit |-> io_offset == 4'h0);

    assert_rom_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (!mem_rd_n && mem_addr[19]));

    assert_rom_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (base_rdata[7:6] == 2'b00) |-> !rom_sel);

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_pcmcia && load_en) |=> (mode_pcmcia || base_rdata == ($past(load_data) | 16'h0001)));

    assert_pcmcia_default_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pcmcia |-> base_rdata == 16'h1867);

    assert_reserved_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        base_rdata[0]);
endmodule

bind isa_addr_decode isadec_checker u_isadec_checker (.*);

// File: tb/test_isa_addr_decode.sv
module test_isa_addr_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_pcmcia = 1'b0;
    logic [15:0] io_addr = '0;
    logic [23:0] mem_addr = '0;
    logic        mem_rd_n = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [15:0] host_wr_data = '0;
    logic        load_en = 1'b0;
    logic [15:0] load_data = '0;
    logic        io_hit;
    logic [3:0]  io_offset;
    logic        rom_sel;
    logic [15:0] base_rdata;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    isa_addr_decode i_isa_addr_decode (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit ref_io(input logic [15:0] b, input logic [15:0] a);
        return a[15:13] == b[15:13] && a[9:5] == b[12:8] && a[12:10] == 3'b000 && !a[4];
    endfunction

    function automatic bit ref_rom(input logic [15:0] b, input logic [23:0] m, input logic rdn);
        bit match;
        case (b[7:6])
            2'b01:   match = m[18:14] == b[5:1];
            2'b10:   match = m[18:15] == b[5:2];
            2'b11:   match = m[18:16] == b[5:3];
            default: match = 1'b0;
        endcase
        return match && m[19] && !rdn;
    endfunction

    task automatic host_write(input logic [15:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
        #1;
    endtask

    task automatic sweep_io(input logic [15:0] b, input string tag);
        int bad = 0;
        for (int a = 0; a < 65536; a++) begin
            logic exp_hit;
            io_addr = 16'(a);
            #1;
            exp_hit = ref_io(b, 16'(a));
            if (io_hit !== exp_hit) begin
                bad++;
                if (bad < 4) check(1'b0, {"R2 ", tag}, {31'd0, io_hit}, {31'd0, exp_hit});
            end
            if (io_offset !== (exp_hit ? 4'(a) : 4'h0)) begin
                bad++;
                if (bad < 4) check(1'b0, {"R3 ", tag}, {28'd0, io_offset}, {28'd0, exp_hit ? 4'(a) : 4'h0});
            end
        end
        check(bad == 0, {"R2/R3 sweep ", tag}, bad, 0);
    endtask

    task automatic sweep_rom(input logic [15:0] b, input string tag);
        int bad = 0;
        for (int hi = 0; hi < 1024; hi++) begin
            for (int r = 0; r < 2; r++) begin
                logic exp_sel;
                mem_addr = {10'(hi), 14'h2A5A ^ 14'(hi)};
                mem_rd_n = r[0];
                #1;
                exp_sel = ref_rom(b, mem_addr, mem_rd_n);
                if (rom_sel !== exp_sel) begin
                    bad++;
                    if (bad < 4) check(1'b0, {"R4/R5/R6 ", tag}, {31'd0, rom_sel}, {31'd0, exp_sel});
                end
            end
        end
        check(bad == 0, {"R4/R5/R6 sweep ", tag}, bad, 0);
        mem_rd_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value
        check(base_rdata == 16'h1867, "R1 reset value", base_rdata, 16'h1867);
        io_addr = 16'h0305; #1;
        check(io_hit && io_offset == 4'h5, "R1 default io base 300h", {27'd0, io_hit, io_offset}, 32'h15);
        mem_addr = 24'h0CC123; mem_rd_n = 1'b0; #1;
        check(rom_sel, "R1 default rom base CC000h", rom_sel, 1);
        mem_rd_n = 1'b1;

        sweep_io(16'h1867, "default");
        sweep_rom(16'h1867, "default 16K");

        // R7 host write, R10 reserved bit forced
        host_write(16'hFF00);
        check(base_rdata == 16'hFF01, "R7/R10 host write", base_rdata, 16'hFF01);
        sweep_io(16'hFF01, "all ones");
        host_write(16'hA500);
        check(base_rdata == 16'hA501, "R7 host write pattern", base_rdata, 16'hA501);
        sweep_io(16'hA501, "alternating");

        // R4/R6 ROM sizes
        for (int s = 0; s < 4; s++) begin
            logic [15:0] v;
            v = {8'h18, 2'(s), 5'b10110, 1'b0};
            host_write(v);
            check(base_rdata == (v | 16'h1), "R10 readback after write", base_rdata, v | 16'h1);
            sweep_rom(v | 16'h1, $sformatf("size %0d", s));
        end

        // R8 load alone and load vs host write
        @(negedge clk);
        load_en = 1'b1; load_data = 16'h2222;
        @(negedge clk);
        load_en = 1'b0; #1;
        check(base_rdata == 16'h2223, "R8 load alone", base_rdata, 16'h2223);
        @(negedge clk);
        load_en = 1'b1; load_data = 16'h4C80;
        host_wr_en = 1'b1; host_wr_data = 16'h1234;
        @(negedge clk);
        load_en = 1'b0; host_wr_en = 1'b0; #1;
        check(base_rdata == 16'h4C81, "R8 load beats host write", base_rdata, 16'h4C81);

        // R9 PCMCIA mode
        @(negedge clk);
        mode_pcmcia = 1'b1; #1;
        check(base_rdata == 16'h1867, "R9 pcmcia readback", base_rdata, 16'h1867);
        host_write(16'h0000);
        check(base_rdata == 16'h1867, "R9 host write ignored", base_rdata, 16'h1867);
        @(negedge clk);
        load_en = 1'b1; load_data = 16'hFFFF;
        @(negedge clk);
        load_en = 1'b0; #1;
        check(base_rdata == 16'h1867, "R9 load ignored", base_rdata, 16'h1867);
        io_addr = 16'h030A; #1;
        check(io_hit && io_offset == 4'hA, "R9 io decode uses default", {27'd0, io_hit, io_offset}, 32'h1A);
        io_addr = 16'h0310; #1;
        check(!io_hit, "R2 A4 set misses", io_hit, 0);
        mem_addr = 24'hFCC000; mem_rd_n = 1'b0; #1;
        check(rom_sel, "R5 A23-A20 ignored", rom_sel, 1);
        mem_addr = 24'h04C000; #1;
        check(!rom_sel, "R5 A19 low misses", rom_sel, 0);
        mem_rd_n = 1'b1;
        @(negedge clk);
        mode_pcmcia = 1'b0;
        @(negedge clk); #1;
        check(base_rdata == 16'h1867, "R9 default kept after return to ISA", base_rdata, 16'h1867);

        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) check(1'b0, "watchdog", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule